// File: doc/BRIEF.md
# Two-Period Hybrid Buck Switching Sequencer

This block times the power switches of a buck stage whose input is split by two series capacitors. It works in frames of two switching periods. In the first period the inductor draws from the upper capacitor for an on-time and then freewheels. In the second period it draws from the lower capacitor and then freewheels again. If both draws last equally long, the two capacitors give up the same charge.

A one-bit tap comparator reports which capacitor currently holds the higher voltage. At each frame start the sequencer lengthens the draw from that capacitor by a balance step and shortens the draw from the other by the same step. This pushes the capacitor voltages back toward each other. The duty command, the balance step, the comparator and the period setting are captured only at a frame boundary, so a pulse is never cut short partway through a frame.

The outputs are three one-hot mode lines (upper draw, freewheel, lower draw), a frame-start strobe and the index of the current period within the frame. A downstream dead-time and gate-drive stage consumes these lines.

Top module: `hbk_frame_seq`

## Requirements
- R1: While `rst_n` is low, `freewheel_o` is 1 and `src_hi_o`, `src_lo_o`, `frame_start_o` and `half_idx_o` are 0.
- R2: `frame_start_o` is 1 in the first cycle after the first rising clock edge with `rst_n` high. After that it is 1 once every 2×P cycles, for exactly one cycle, where P is the period length.
- R3: Each frame has two halves of P cycles each. `half_idx_o` is 0 in the first half and 1 in the second. P is `period_i` as captured at frame start, and a value below 2 is treated as 2.
- R4: `src_hi_o` is 1 for the first ON_HI cycles of half 0. `src_lo_o` is 1 for the first ON_LO cycles of half 1. In every other cycle `freewheel_o` is 1. The order within a frame is therefore: upper draw, freewheel, lower draw, freewheel.
- R5: With `step_i` = 0, ON_HI = ON_LO = min(`duty_i`, P-1).
- R6: With `upper_hi_i` = 1 (upper capacitor voltage higher), ON_HI = `duty_i` + `step_i` and ON_LO = `duty_i` − `step_i`.
- R7: With `upper_hi_i` = 0 (lower capacitor voltage higher), ON_HI = `duty_i` − `step_i` and ON_LO = `duty_i` + `step_i`.
- R8: Each on-time is clamped to the range 0 to P−1. A difference that would be negative becomes 0.
- R9: An on-time of 0 produces no sourcing cycle in that half; the whole half is freewheel.
- R10: Changes to `duty_i`, `step_i`, `upper_hi_i` or `period_i` during a frame have no effect until the next frame start.
- R11: In every cycle exactly one of `src_hi_o`, `freewheel_o`, `src_lo_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | CNT_W | Nominal on-time per period, in clock cycles |
| period_i | input | CNT_W | Switching period, in clock cycles |
| step_i | input | CNT_W | Balance skew added to one on-time and removed from the other |
| upper_hi_i | input | 1 | 1 when the upper capacitor voltage is higher |
| src_hi_o | output | 1 | Inductor draws from the upper capacitor |
| freewheel_o | output | 1 | Freewheeling mode |
| src_lo_o | output | 1 | Inductor draws from the lower capacitor |
| frame_start_o | output | 1 | First cycle of a frame |
| half_idx_o | output | 1 | Index of the period within the frame (0 or 1) |

## Verification
Several properties are checked by assertions on every cycle:
- the mode lines are one-hot;
- an upper draw only happens in half 0 and a lower draw only in half 1;
- the counter stays below the latched period, and the halves alternate;
- the latched on-times stay below the period, hold steady between frame starts, and lean toward the capacitor flagged as higher.

The exact on-time values after the sum, difference and clamp need the bench's directed scenarios. The same is true of the delay from reset to the first frame, the treatment of very short periods, and the fact that a duty change mid-frame waits for the next frame. For these the bench counts cycles over whole frames and compares them with values it works out itself.

// File: rtl/hbk_pkg.sv
package hbk_pkg;
  typedef enum logic [1:0] {
    MD_FREE   = 2'd0,
    MD_SRC_HI = 2'd1,
    MD_SRC_LO = 2'd2
  } hbk_mode_e;

  localparam int unsigned HBK_MIN_PERIOD = 2;
endpackage

// File: rtl/hbk_frame_timer.sv
module hbk_frame_timer
  import hbk_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             half_o,
  output logic [CNT_W-1:0] per_q_o,
  output logic [CNT_W-1:0] per_nxt_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(HBK_MIN_PERIOD);

  function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] p);
    return (p < MIN_P) ? MIN_P : p;
  endfunction

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             half_q;
  logic [CNT_W-1:0] per_q;
  logic             half_end;

  assign half_end  = (cnt_q == per_q - CNT_W'(1));
  assign load_o    = !run_q || (half_q && half_end);
  assign per_nxt_o = eff_period(period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= 1'b0;
      per_q  <= MIN_P;
    end else if (load_o) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      half_q <= 1'b0;
      per_q  <= per_nxt_o;
    end else if (half_end) begin
      cnt_q  <= '0;
      half_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign run_o   = run_q;
  assign cnt_o   = cnt_q;
  assign half_o  = half_q;
  assign per_q_o = per_q;

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q)); // R3
  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    per_q >= MIN_P); // R3
  AST_HALF_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !half_q && half_end) |=> (half_q && cnt_q == '0)); // R3
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && half_q && half_end) |=> (!half_q && cnt_q == '0)); // R2
endmodule

// File: rtl/hbk_ontime_calc.sv
module hbk_ontime_calc #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic             upper_hi_i,
  input  logic [CNT_W-1:0] per_nxt_i,
  input  logic [CNT_W-1:0] per_q_i,
  output logic [CNT_W-1:0] on_hi_o,
  output logic [CNT_W-1:0] on_lo_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  function automatic logic [CNT_W-1:0] clamp_top(input logic [EXT_W-1:0] v,
                                                 input logic [CNT_W-1:0] lim);
    return (v > {1'b0, lim}) ? lim : v[CNT_W-1:0];
  endfunction

  function automatic logic [EXT_W-1:0] add_skew(input logic [CNT_W-1:0] d,
                                                input logic [CNT_W-1:0] s);
    return {1'b0, d} + {1'b0, s};
  endfunction

  function automatic logic [EXT_W-1:0] sub_skew(input logic [CNT_W-1:0] d,
                                                input logic [CNT_W-1:0] s);
    return (s > d) ? '0 : ({1'b0, d} - {1'b0, s});
  endfunction

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] long_t;
  logic [CNT_W-1:0] short_t;
  logic [CNT_W-1:0] on_hi_q;
  logic [CNT_W-1:0] on_lo_q;

  assign lim     = per_nxt_i - CNT_W'(1);
  assign long_t  = clamp_top(add_skew(duty_i, step_i), lim);
  assign short_t = clamp_top(sub_skew(duty_i, step_i), lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_hi_q <= '0;
      on_lo_q <= '0;
    end else if (load_i) begin
      on_hi_q <= upper_hi_i ? long_t : short_t;
      on_lo_q <= upper_hi_i ? short_t : long_t;
    end
  end

  assign on_hi_o = on_hi_q;
  assign on_lo_o = on_lo_q;

  AST_ON_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (on_hi_q < per_q_i && on_lo_q < per_q_i)); // R8
  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(on_hi_q) && $stable(on_lo_q))); // R10
  AST_SKEW_TO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && upper_hi_i) |=> (on_hi_q >= on_lo_q)); // R6
  AST_SKEW_TO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !upper_hi_i) |=> (on_lo_q >= on_hi_q)); // R7
endmodule

// File: rtl/hbk_mode_decode.sv
module hbk_mode_decode
  import hbk_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             half_i,
  input  logic [CNT_W-1:0] on_hi_i,
  input  logic [CNT_W-1:0] on_lo_i,
  output logic             src_hi_o,
  output logic             freewheel_o,
  output logic             src_lo_o,
  output logic             frame_start_o,
  output logic             half_idx_o
);
  hbk_mode_e mode;
  logic      in_hi_pulse;
  logic      in_lo_pulse;

  assign in_hi_pulse = run_i && !half_i && (cnt_i < on_hi_i);
  assign in_lo_pulse = run_i &&  half_i && (cnt_i < on_lo_i);

  always_comb begin
    mode = MD_FREE;
    if (in_hi_pulse)      mode = MD_SRC_HI;
    else if (in_lo_pulse) mode = MD_SRC_LO;
  end

  assign src_hi_o      = (mode == MD_SRC_HI);
  assign src_lo_o      = (mode == MD_SRC_LO);
  assign freewheel_o   = (mode == MD_FREE);
  assign frame_start_o = run_i && !half_i && (cnt_i == '0);
  assign half_idx_o    = run_i && half_i;

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({src_hi_o, freewheel_o, src_lo_o}) == 1); // R11
  AST_HI_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    src_hi_o |-> !half_idx_o); // R4
  AST_LO_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    src_lo_o |-> half_idx_o); // R4
  AST_START_IN_HALF0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> !half_idx_o); // R2
endmodule

// File: rtl/hbk_frame_seq.sv
module hbk_frame_seq
  import hbk_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic             upper_hi_i,
  output logic             src_hi_o,
  output logic             freewheel_o,
  output logic             src_lo_o,
  output logic             frame_start_o,
  output logic             half_idx_o
);
  logic             run;
  logic [CNT_W-1:0] cnt;
  logic             half;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] per_nxt;
  logic             load;
  logic [CNT_W-1:0] on_hi;
  logic [CNT_W-1:0] on_lo;

  hbk_frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_i  (period_i),
    .run_o     (run),
    .cnt_o     (cnt),
    .half_o    (half),
    .per_q_o   (per_q),
    .per_nxt_o (per_nxt),
    .load_o    (load)
  );

  hbk_ontime_calc #(.CNT_W(CNT_W)) u_ontime (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .duty_i     (duty_i),
    .step_i     (step_i),
    .upper_hi_i (upper_hi_i),
    .per_nxt_i  (per_nxt),
    .per_q_i    (per_q),
    .on_hi_o    (on_hi),
    .on_lo_o    (on_lo)
  );

  hbk_mode_decode #(.CNT_W(CNT_W)) u_decode (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .cnt_i         (cnt),
    .half_i        (half),
    .on_hi_i       (on_hi),
    .on_lo_i       (on_lo),
    .src_hi_o      (src_hi_o),
    .freewheel_o   (freewheel_o),
    .src_lo_o      (src_lo_o),
    .frame_start_o (frame_start_o),
    .half_idx_o    (half_idx_o)
  );

  AST_FIRST_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> frame_start_o); // R2
endmodule

// File: tb/hbk_frame_seq_bench.sv
module hbk_frame_seq_bench;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] duty_i = '0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] step_i = '0;
  logic             upper_hi_i = 1'b0;
  logic             src_hi_o, freewheel_o, src_lo_o, frame_start_o, half_idx_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  hbk_frame_seq #(.CNT_W(CNT_W)) u_hbk_frame_seq (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .period_i(period_i),
    .step_i(step_i), .upper_hi_i(upper_hi_i), .src_hi_o(src_hi_o),
    .freewheel_o(freewheel_o), .src_lo_o(src_lo_o),
    .frame_start_o(frame_start_o), .half_idx_o(half_idx_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model of the on-times (signed arithmetic, then clamp).
  function automatic int model_on(input int d, input int s, input int p, input bit longer);
    int v;
    v = longer ? d + s : d - s;
    if (v < 0) v = 0;
    if (v > p - 1) v = p - 1;
    return v;
  endfunction

  function automatic int model_p(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  task automatic set_in(input int d, input int p, input int s, input bit hi);
    @(negedge clk);
    duty_i = CNT_W'(d); period_i = CNT_W'(p); step_i = CNT_W'(s); upper_hi_i = hi;
  endtask

  // Find the next frame start, then verify a whole frame cycle by cycle.
  task automatic run_frame(input int p, input int ea, input int ec, input string tag,
                           input int mid_duty);
    int guard = 0;
    int ca = 0, cc = 0, pat_err = 0, hot_err = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!frame_start_o && guard < 2000);
    check(frame_start_o == 1'b1, "R2", {tag, " frame start seen"}, frame_start_o, 1);
    for (int i = 0; i < 2 * p; i++) begin
      bit xa = (i < p) && (i < ea);
      bit xc = (i >= p) && (i - p < ec);
      if (src_hi_o != xa || src_lo_o != xc || freewheel_o != !(xa || xc) ||
          half_idx_o != (i >= p) || frame_start_o != (i == 0))
        pat_err++;
      if ($countones({src_hi_o, freewheel_o, src_lo_o}) != 1) hot_err++;
      ca += int'(src_hi_o);
      cc += int'(src_lo_o);
      if (mid_duty >= 0 && i == 2) duty_i = CNT_W'(mid_duty);
      @(negedge clk);
    end
    check(frame_start_o == 1'b1, "R3", {tag, " next frame after 2P"}, frame_start_o, 1);
    check(ca == ea, tag, "upper draw cycles", ca, ea);
    check(cc == ec, tag, "lower draw cycles", cc, ec);
    check(pat_err == 0, "R4", {tag, " mode order pattern errors"}, pat_err, 0);
    check(hot_err == 0, "R11", {tag, " one-hot errors"}, hot_err, 0);
  endtask

  task automatic t_reset_and_first;
    set_in(3, 8, 0, 1'b1);
    repeat (3) @(negedge clk);
    check(freewheel_o == 1'b1, "R1", "freewheel in reset", freewheel_o, 1);
    check({src_hi_o, src_lo_o, frame_start_o, half_idx_o} == 4'b0, "R1",
          "other outputs in reset", {src_hi_o, src_lo_o, frame_start_o, half_idx_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_start_o == 1'b1, "R2", "first frame right after reset", frame_start_o, 1);
    check(src_hi_o == 1'b1, "R4", "upper draw opens first frame", src_hi_o, 1);
  endtask

  task automatic t_balanced;
    set_in(3, 8, 0, 1'b1);
    run_frame(8, 3, 3, "R5", -1);
    set_in(9, 6, 0, 1'b0);
    run_frame(6, 5, 5, "R5", -1);
  endtask

  task automatic t_skew_upper;
    set_in(3, 8, 2, 1'b1);
    run_frame(8, model_on(3, 2, 8, 1'b1), model_on(3, 2, 8, 1'b0), "R6", -1);
  endtask

  task automatic t_skew_lower;
    set_in(3, 8, 2, 1'b0);
    run_frame(8, model_on(3, 2, 8, 1'b0), model_on(3, 2, 8, 1'b1), "R7", -1);
  endtask

  task automatic t_clamp;
    set_in(6, 8, 4, 1'b1);
    run_frame(8, 7, 2, "R8", -1);
    set_in(2, 8, 5, 1'b0);
    run_frame(8, 0, 7, "R8", -1);
  endtask

  task automatic t_zero_on;
    set_in(0, 10, 0, 1'b1);
    run_frame(10, 0, 0, "R9", -1);
  endtask

  task automatic t_short_period;
    set_in(1, 1, 0, 1'b1);
    run_frame(model_p(1), 1, 1, "R3", -1);
    set_in(1, 0, 0, 1'b0);
    run_frame(model_p(0), 1, 1, "R3", -1);
  endtask

  task automatic t_midframe;
    set_in(4, 12, 1, 1'b1);
    run_frame(12, 5, 3, "R10", 9);
    run_frame(12, model_on(9, 1, 12, 1'b1), model_on(9, 1, 12, 1'b0), "R10", -1);
  endtask

  initial begin
    t_reset_and_first();
    t_balanced();
    t_skew_upper();
    t_skew_lower();
    t_clamp();
    t_zero_on();
    t_short_period();
    t_midframe();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule